// File: doc/BRIEF.md
# Per-Bank Static Memory Timing and Status Register File

This block holds the timing and control settings for eight external static memory banks, together with a sticky error record for each bank. A host writes and reads it through a plain 32-bit register port with a byte offset, a write strobe and a combinational read path. The access sequencer that drives the memory pins reads every bank's settings continuously from flattened configuration outputs. It also reports error events back through single-cycle pulses tagged with a bank number.

Each bank owns seven word registers in a fixed order: turn-around cycles, read wait states, write/burst wait states, output-enable delay, write-enable delay, control, and status. Bank groups follow one another every 0x1C bytes. Just past the last group, one read-only word reports the external wait input. It shows the live level only while a waited transfer that ended early is still being tracked. Each bank powers up with its own memory width. The last bank instead loads its width from two boot pins, so a boot device of any width can be reached.

Top module: `bank_cfg_regs`

## Requirements
- R1: Register word r (0 to 6) of bank b sits at byte offset b*0x1C + 4*r, where r is 0 turn-around, 1 read wait, 2 write/burst wait, 3 output-enable delay, 4 write-enable delay, 5 control, 6 status. A read returns the field zero-extended.
- R2: After reset the turn-around field is 0xF, both wait fields are 0x1F, both enable delays and all status flags are 0, and control bits 5:0 are 0.
- R3: Control bits 7:6 hold the memory width (00 8-bit, 01 16-bit, 10 32-bit, 11 reserved). After reset they are 10 for banks 0, 4 and 5, 01 for banks 2 and 6, and 00 for banks 1 and 3. Bank 7 takes the value on boot_width_i during reset.
- R4: Control bit 5 is burst, bit 4 write protect, bit 3 chip-select polarity, bit 2 wait enable, bit 1 wait polarity, and bit 0 read byte-lane enable. All eight control bits are writable. Bank b's fields appear on slice b of each cfg output.
- R5: Bits above a field's width (4 for turn-around and both delays, 5 for the wait fields, 8 for control, 3 for status) read as zero, and written values there are dropped.
- R6: A pulse on evt_size_i, evt_wprot_i or evt_tout_i sets status bit 0, 1 or 2, respectively, of the bank named by evt_bank_i. The bit then stays set.
- R7: Writing a 1 to a status bit clears that bit. Writing a 0 leaves it unchanged.
- R8: When an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R9: At offset 0xE0, bit 0 equals wait_act_i while the tracker is armed, and reads 0 otherwise. An early_term_i pulse arms the tracker. A cycle with wait_act_i low and no early_term_i disarms it. Writes to this offset are ignored.
- R10: Misaligned offsets and offsets above 0xE0 read zero, and writes to them change nothing.
- R11: A write changes its register at that clock edge. Configuration outputs stay unchanged in any cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_width_i | input | 2 | Reset memory width for bank 7 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Byte offset of the access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| evt_bank_i | input | 3 | Bank that an error event refers to |
| evt_size_i | input | 1 | Transfer size error pulse |
| evt_wprot_i | input | 1 | Write-protect error pulse |
| evt_tout_i | input | 1 | Wait timeout error pulse |
| early_term_i | input | 1 | A waited transfer ended early |
| wait_act_i | input | 1 | External wait input, already in asserted-high form |
| cfg_idle_o | output | 32 | Turn-around cycles, 4 bits per bank |
| cfg_wst1_o | output | 40 | Read wait states, 5 bits per bank |
| cfg_wst2_o | output | 40 | Write/burst wait states, 5 bits per bank |
| cfg_oen_o | output | 32 | Output-enable delay, 4 bits per bank |
| cfg_wen_o | output | 32 | Write-enable delay, 4 bits per bank |
| cfg_ctrl_o | output | 64 | Control byte, 8 bits per bank |

## Verification
The assertions check the following on every cycle:
- each status flag stays set until a write-1 reaches it, is raised by its event, and survives a simultaneous clear;
- the configuration outputs never move without a write;
- an unmapped or disarmed wait-status read returns zero;
- the wait tracker disarms once the wait input is seen low.

The address order of the seven registers, the per-bank reset widths, the width loaded from the boot pins, the truncation of reserved bits, and the arming sequence around an early-terminated transfer are shown only by the bench's scenarios. These are compared cycle by cycle against a behavioural model.

// File: rtl/bankcfg_pkg.sv
package bankcfg_pkg;
  localparam int ADDR_W        = 12;
  localparam int DATA_W        = 32;
  localparam int IDLE_W        = 4;
  localparam int WST_W         = 5;
  localparam int DLY_W         = 4;
  localparam int CTRL_W        = 8;
  localparam int STS_W         = 3;
  localparam int REGS_PER_BANK = 7;
  localparam int MW_LSB        = 6;

  typedef enum logic [2:0] {
    RI_IDLE = 3'd0,
    RI_WST1 = 3'd1,
    RI_WST2 = 3'd2,
    RI_OEN  = 3'd3,
    RI_WEN  = 3'd4,
    RI_CTRL = 3'd5,
    RI_STS  = 3'd6
  } reg_idx_e;

  typedef struct packed {
    logic     hit_bank;
    logic     hit_ews;
    logic [7:0] bank;
    reg_idx_e ridx;
  } dec_t;

  // Byte offset -> bank / register; the wait-status word follows the last bank.
  function automatic dec_t decode_offset(input logic [ADDR_W-1:0] a, input int nb);
    dec_t d;
    int   w;
    d = '0;
    w = int'(a[ADDR_W-1:2]);
    if (a[1:0] == 2'b00) begin
      if (w < nb * REGS_PER_BANK) begin
        d.hit_bank = 1'b1;
        d.bank     = 8'(w / REGS_PER_BANK);
        d.ridx     = reg_idx_e'(3'(w % REGS_PER_BANK));
      end else if (w == nb * REGS_PER_BANK) begin
        d.hit_ews = 1'b1;
      end
    end
    return d;
  endfunction

  // Sticky flags: clear by write-1, set has priority.
  function automatic logic [STS_W-1:0] sts_next(input logic [STS_W-1:0] cur,
                                                input logic [STS_W-1:0] clr,
                                                input logic [STS_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/bankcfg_group.sv
module bankcfg_group
  import bankcfg_pkg::*;
#(
  parameter logic [1:0] RST_MW = 2'b00,
  parameter bit         PIN_MW = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        boot_width_i,
  input  logic              wr_en_i,
  input  reg_idx_e          idx_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic [STS_W-1:0]  set_i,
  output logic [DATA_W-1:0] rd_o,
  output logic [IDLE_W-1:0] idle_o,
  output logic [WST_W-1:0]  wst1_o,
  output logic [WST_W-1:0]  wst2_o,
  output logic [DLY_W-1:0]  oen_o,
  output logic [DLY_W-1:0]  wen_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [STS_W-1:0]  sts_o
);
  logic [IDLE_W-1:0] idle_q;
  logic [WST_W-1:0]  wst1_q, wst2_q;
  logic [DLY_W-1:0]  oen_q, wen_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [STS_W-1:0]  sts_q;
  logic [1:0]        rst_mw;
  logic [STS_W-1:0]  sts_clr;

  assign rst_mw  = PIN_MW ? boot_width_i : RST_MW;
  assign sts_clr = (wr_en_i && idx_i == RI_STS) ? wdata_i[STS_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q <= '1;
      wst1_q <= '1;
      wst2_q <= '1;
      oen_q  <= '0;
      wen_q  <= '0;
      ctrl_q <= CTRL_W'({rst_mw, MW_LSB'(0)});
      sts_q  <= '0;
    end else begin
      if (wr_en_i) begin
        case (idx_i)
          RI_IDLE: idle_q <= wdata_i[IDLE_W-1:0];
          RI_WST1: wst1_q <= wdata_i[WST_W-1:0];
          RI_WST2: wst2_q <= wdata_i[WST_W-1:0];
          RI_OEN:  oen_q  <= wdata_i[DLY_W-1:0];
          RI_WEN:  wen_q  <= wdata_i[DLY_W-1:0];
          RI_CTRL: ctrl_q <= wdata_i;
          default: ;
        endcase
      end
      sts_q <= sts_next(sts_q, sts_clr, set_i);
    end
  end

  always_comb begin
    case (idx_i)
      RI_IDLE: rd_o = DATA_W'(idle_q);
      RI_WST1: rd_o = DATA_W'(wst1_q);
      RI_WST2: rd_o = DATA_W'(wst2_q);
      RI_OEN:  rd_o = DATA_W'(oen_q);
      RI_WEN:  rd_o = DATA_W'(wen_q);
      RI_CTRL: rd_o = DATA_W'(ctrl_q);
      RI_STS:  rd_o = DATA_W'(sts_q);
      default: rd_o = '0;
    endcase
  end

  assign idle_o = idle_q;
  assign wst1_o = wst1_q;
  assign wst2_o = wst2_q;
  assign oen_o  = oen_q;
  assign wen_o  = wen_q;
  assign ctrl_o = ctrl_q;
  assign sts_o  = sts_q;
endmodule

// File: rtl/bankcfg_ews.sv
module bankcfg_ews (
  input  logic clk,
  input  logic rst_n,
  input  logic early_term_i,
  input  logic wait_act_i,
  output logic armed_o,
  output logic status_o
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              armed_q <= 1'b0;
    else if (early_term_i)   armed_q <= 1'b1;
    else if (!wait_act_i)    armed_q <= 1'b0;
  end

  assign armed_o  = armed_q;
  assign status_o = armed_q & wait_act_i;
endmodule

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs
  import bankcfg_pkg::*;
#(
  parameter int                NB         = 8,
  parameter logic [2*NB-1:0]   RST_MW_MAP = 16'h1A12,
  parameter int                BOOT_BANK  = NB - 1,
  localparam int               BANK_W     = $clog2(NB)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           boot_width_i,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic [BANK_W-1:0]    evt_bank_i,
  input  logic                 evt_size_i,
  input  logic                 evt_wprot_i,
  input  logic                 evt_tout_i,
  input  logic                 early_term_i,
  input  logic                 wait_act_i,
  output logic [NB*IDLE_W-1:0] cfg_idle_o,
  output logic [NB*WST_W-1:0]  cfg_wst1_o,
  output logic [NB*WST_W-1:0]  cfg_wst2_o,
  output logic [NB*DLY_W-1:0]  cfg_oen_o,
  output logic [NB*DLY_W-1:0]  cfg_wen_o,
  output logic [NB*CTRL_W-1:0] cfg_ctrl_o
);
  dec_t              dec;
  logic [DATA_W-1:0] bank_rd [NB];
  logic [DATA_W-1:0] bank_sel_rd;
  logic [NB*STS_W-1:0] sts_flat;
  logic [NB-1:0]     sts_wr_sel;
  logic              ews_armed, ews_bit, ews_rd_hit, unmapped_hit;
  logic [STS_W-1:0]  evt_vec;
  logic              unused_wdata_hi;

  assign dec             = decode_offset(reg_addr_i, NB);
  assign ews_rd_hit      = dec.hit_ews;
  assign unmapped_hit    = !dec.hit_bank && !dec.hit_ews;
  assign evt_vec         = {evt_tout_i, evt_wprot_i, evt_size_i};
  assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:CTRL_W];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic wr_b;
    assign wr_b          = reg_wr_i && dec.hit_bank && (dec.bank == 8'(b));
    assign sts_wr_sel[b] = wr_b && (dec.ridx == RI_STS);

    bankcfg_group #(
      .RST_MW (RST_MW_MAP[2*b +: 2]),
      .PIN_MW (b == BOOT_BANK)
    ) grp_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .boot_width_i (boot_width_i),
      .wr_en_i      (wr_b),
      .idx_i        (dec.ridx),
      .wdata_i      (reg_wdata_i[CTRL_W-1:0]),
      .set_i        ((evt_bank_i == BANK_W'(b)) ? evt_vec : '0),
      .rd_o         (bank_rd[b]),
      .idle_o       (cfg_idle_o[b*IDLE_W +: IDLE_W]),
      .wst1_o       (cfg_wst1_o[b*WST_W +: WST_W]),
      .wst2_o       (cfg_wst2_o[b*WST_W +: WST_W]),
      .oen_o        (cfg_oen_o[b*DLY_W +: DLY_W]),
      .wen_o        (cfg_wen_o[b*DLY_W +: DLY_W]),
      .ctrl_o       (cfg_ctrl_o[b*CTRL_W +: CTRL_W]),
      .sts_o        (sts_flat[b*STS_W +: STS_W])
    );
  end

  bankcfg_ews ews_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .early_term_i (early_term_i),
    .wait_act_i   (wait_act_i),
    .armed_o      (ews_armed),
    .status_o     (ews_bit)
  );

  always_comb begin
    bank_sel_rd = '0;
    for (int b = 0; b < NB; b++)
      if (dec.bank == 8'(b)) bank_sel_rd = bank_rd[b];
  end

  always_comb begin
    if (dec.hit_bank)     reg_rdata_o = bank_sel_rd;
    else if (dec.hit_ews) reg_rdata_o = DATA_W'(ews_bit);
    else                  reg_rdata_o = '0;
  end
endmodule

// File: rtl/bank_cfg_regs_chk.sv
module bank_cfg_regs_chk
  import bankcfg_pkg::*;
#(
  parameter int NB = 8,
  localparam int BANK_W = $clog2(NB)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr_i,
  input logic [DATA_W-1:0]    reg_wdata_i,
  input logic [DATA_W-1:0]    reg_rdata_o,
  input logic [BANK_W-1:0]    evt_bank_i,
  input logic                 evt_size_i,
  input logic                 evt_wprot_i,
  input logic                 evt_tout_i,
  input logic                 early_term_i,
  input logic                 wait_act_i,
  input logic [NB*STS_W-1:0]  sts_flat,
  input logic [NB-1:0]        sts_wr_sel,
  input logic                 ews_armed,
  input logic                 ews_rd_hit,
  input logic                 unmapped_hit,
  input logic [NB*IDLE_W-1:0] cfg_idle_o,
  input logic [NB*WST_W-1:0]  cfg_wst1_o,
  input logic [NB*WST_W-1:0]  cfg_wst2_o,
  input logic [NB*DLY_W-1:0]  cfg_oen_o,
  input logic [NB*DLY_W-1:0]  cfg_wen_o,
  input logic [NB*CTRL_W-1:0] cfg_ctrl_o
);
  logic [STS_W-1:0] ev;
  assign ev = {evt_tout_i, evt_wprot_i, evt_size_i};

  for (genvar b = 0; b < NB; b++) begin : g_b
    for (genvar k = 0; k < STS_W; k++) begin : g_k
      p_event_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[k] && evt_bank_i == BANK_W'(b)) |=> sts_flat[b*STS_W+k]);
      p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_flat[b*STS_W+k] && !(sts_wr_sel[b] && reg_wdata_i[k])) |=> sts_flat[b*STS_W+k]);
      p_w1_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr_sel[b] && reg_wdata_i[k] && !(ev[k] && evt_bank_i == BANK_W'(b)))
          |=> !sts_flat[b*STS_W+k]);
      p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr_sel[b] && reg_wdata_i[k] && ev[k] && evt_bank_i == BANK_W'(b))
          |=> sts_flat[b*STS_W+k]);
    end
  end

  p_cfg_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_i |=> ($stable(cfg_idle_o) && $stable(cfg_wst1_o) && $stable(cfg_wst2_o) &&
                   $stable(cfg_oen_o) && $stable(cfg_wen_o) && $stable(cfg_ctrl_o)));
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_hit |-> (reg_rdata_o == '0));
  p_ews_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ews_armed && !wait_act_i && !early_term_i) |=> !ews_armed);
  p_ews_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ews_rd_hit && !ews_armed) |-> (reg_rdata_o == '0));
endmodule

bind bank_cfg_regs bank_cfg_regs_chk #(.NB(NB)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr_i     (reg_wr_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .evt_bank_i   (evt_bank_i),
  .evt_size_i   (evt_size_i),
  .evt_wprot_i  (evt_wprot_i),
  .evt_tout_i   (evt_tout_i),
  .early_term_i (early_term_i),
  .wait_act_i   (wait_act_i),
  .sts_flat     (sts_flat),
  .sts_wr_sel   (sts_wr_sel),
  .ews_armed    (ews_armed),
  .ews_rd_hit   (ews_rd_hit),
  .unmapped_hit (unmapped_hit),
  .cfg_idle_o   (cfg_idle_o),
  .cfg_wst1_o   (cfg_wst1_o),
  .cfg_wst2_o   (cfg_wst2_o),
  .cfg_oen_o    (cfg_oen_o),
  .cfg_wen_o    (cfg_wen_o),
  .cfg_ctrl_o   (cfg_ctrl_o)
);

// File: tb/bank_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module bank_cfg_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  boot_width = 2'b01;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  evt_bank = '0;
  logic        evt_size = 1'b0, evt_wprot = 1'b0, evt_tout = 1'b0;
  logic        early_term = 1'b0, wait_act = 1'b0;
  logic [31:0] cfg_idle, cfg_oen, cfg_wen;
  logic [39:0] cfg_wst1, cfg_wst2;
  logic [63:0] cfg_ctrl;

  int n_run = 0, n_fail = 0, n_cyc = 0;

  // behavioural model state
  logic [3:0] m_idle [8];
  logic [4:0] m_wst1 [8];
  logic [4:0] m_wst2 [8];
  logic [3:0] m_oen  [8];
  logic [3:0] m_wen  [8];
  logic [7:0] m_ctrl [8];
  logic [2:0] m_sts  [8];
  logic       m_armed;

  always #2 clk = ~clk;

  bank_cfg_regs dut_i (
    .clk(clk), .rst_n(rst_n), .boot_width_i(boot_width),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .evt_bank_i(evt_bank), .evt_size_i(evt_size), .evt_wprot_i(evt_wprot), .evt_tout_i(evt_tout),
    .early_term_i(early_term), .wait_act_i(wait_act),
    .cfg_idle_o(cfg_idle), .cfg_wst1_o(cfg_wst1), .cfg_wst2_o(cfg_wst2),
    .cfg_oen_o(cfg_oen), .cfg_wen_o(cfg_wen), .cfg_ctrl_o(cfg_ctrl)
  );

  function automatic logic [31:0] mread(input int a);
    int w;
    if (a % 4 != 0) return 32'h0;
    w = a / 4;
    if (w < 56) begin
      case (w % 7)
        0: return 32'(m_idle[w / 7]);
        1: return 32'(m_wst1[w / 7]);
        2: return 32'(m_wst2[w / 7]);
        3: return 32'(m_oen[w / 7]);
        4: return 32'(m_wen[w / 7]);
        5: return 32'(m_ctrl[w / 7]);
        default: return 32'(m_sts[w / 7]);
      endcase
    end
    if (w == 56) return 32'(m_armed & wait_act);
    return 32'h0;
  endfunction

  task automatic model_step();
    int a, bk, rg;
    logic [2:0] clr, set;
    if (!rst_n) begin
      for (int b = 0; b < 8; b++) begin
        m_idle[b] = 4'hF; m_wst1[b] = 5'h1F; m_wst2[b] = 5'h1F;
        m_oen[b] = 0; m_wen[b] = 0; m_sts[b] = 0;
      end
      m_ctrl[0] = 8'h80; m_ctrl[1] = 8'h00; m_ctrl[2] = 8'h40; m_ctrl[3] = 8'h00;
      m_ctrl[4] = 8'h80; m_ctrl[5] = 8'h80; m_ctrl[6] = 8'h40;
      m_ctrl[7] = {boot_width, 6'b0};
      m_armed = 1'b0;
      return;
    end
    a = int'(reg_addr); bk = -1; rg = -1;
    if (reg_wr && a % 4 == 0 && a / 4 < 56) begin bk = (a / 4) / 7; rg = (a / 4) % 7; end
    for (int b = 0; b < 8; b++) begin
      clr = (bk == b && rg == 6) ? reg_wdata[2:0] : 3'b0;
      set = (int'(evt_bank) == b) ? {evt_tout, evt_wprot, evt_size} : 3'b0;
      m_sts[b] = (m_sts[b] & ~clr) | set;
    end
    if (bk >= 0) begin
      case (rg)
        0: m_idle[bk] = reg_wdata[3:0];
        1: m_wst1[bk] = reg_wdata[4:0];
        2: m_wst2[bk] = reg_wdata[4:0];
        3: m_oen[bk]  = reg_wdata[3:0];
        4: m_wen[bk]  = reg_wdata[3:0];
        5: m_ctrl[bk] = reg_wdata[7:0];
        default: ;
      endcase
    end
    if (early_term) m_armed = 1'b1;
    else if (!wait_act) m_armed = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model (R4, R11)
  task automatic compare_all();
    logic [63:0] e_ctrl;
    logic [39:0] e_w1, e_w2;
    logic [31:0] e_id, e_oe, e_we;
    for (int b = 0; b < 8; b++) begin
      e_ctrl[b*8 +: 8] = m_ctrl[b];
      e_w1[b*5 +: 5] = m_wst1[b]; e_w2[b*5 +: 5] = m_wst2[b];
      e_id[b*4 +: 4] = m_idle[b]; e_oe[b*4 +: 4] = m_oen[b]; e_we[b*4 +: 4] = m_wen[b];
    end
    chk("R4 cfg_ctrl", cfg_ctrl, e_ctrl);
    chk("R11 cfg_wst1", 64'(cfg_wst1), 64'(e_w1));
    chk("R11 cfg_wst2", 64'(cfg_wst2), 64'(e_w2));
    chk("R11 cfg_idle", 64'(cfg_idle), 64'(e_id));
    chk("R11 cfg_oen", 64'(cfg_oen), 64'(e_oe));
    chk("R11 cfg_wen", 64'(cfg_wen), 64'(e_we));
    chk("R1 rdata vs model", 64'(reg_rdata), 64'(mread(int'(reg_addr))));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    if (rst_n) compare_all();
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_addr = 12'(a); reg_wdata = d; reg_wr = 1'b1;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    reg_addr = 12'(a); reg_wr = 1'b0;
    cyc();
    chk(tag, 64'(reg_rdata), 64'(exp));
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", n_cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc();
    rst_n = 1'b1;
    boot_width = 2'b10;   // pins move after reset: bank 7 must keep 01
    cyc();

    // R3 reset widths, bank 7 from pins sampled during reset
    rd(8'h14, 32'h80, "R3 bank0 ctrl");
    rd(8'h30, 32'h00, "R3 bank1 ctrl");
    rd(8'h4C, 32'h40, "R3 bank2 ctrl");
    rd(8'h68, 32'h00, "R3 bank3 ctrl");
    rd(8'h84, 32'h80, "R3 bank4 ctrl");
    rd(8'hA0, 32'h80, "R3 bank5 ctrl");
    rd(8'hBC, 32'h40, "R3 bank6 ctrl");
    rd(8'hD8, 32'h40, "R3 bank7 ctrl boot pins");
    // R2 reset values
    rd(8'h54, 32'hF,  "R2 bank3 idle");
    rd(8'h58, 32'h1F, "R2 bank3 wst1");
    rd(8'h5C, 32'h1F, "R2 bank3 wst2");
    rd(8'h60, 32'h0,  "R2 bank3 oen");
    rd(8'h64, 32'h0,  "R2 bank3 wen");
    rd(8'h6C, 32'h0,  "R2 bank3 status");

    // R1 register order within bank 1
    wr(8'h1C, 32'h3);  wr(8'h20, 32'h11); wr(8'h24, 32'h0A);
    wr(8'h28, 32'h5);  wr(8'h2C, 32'h9);  wr(8'h30, 32'h21);
    rd(8'h1C, 32'h3,  "R1 idle");
    rd(8'h20, 32'h11, "R1 wst1");
    rd(8'h24, 32'h0A, "R1 wst2");
    rd(8'h28, 32'h5,  "R1 oen");
    rd(8'h2C, 32'h9,  "R1 wen");
    rd(8'h30, 32'h21, "R1 ctrl");

    // R5 reserved bits dropped; R4 control writable and on its slice
    wr(8'h94, 32'hFFFF_FFE3);
    rd(8'h94, 32'h03, "R5 wst2 truncated");
    chk("R5 bank5 wst2 slice", 64'(cfg_wst2[25 +: 5]), 64'h03);
    wr(8'h4C, 32'hABCD_EF3D);
    rd(8'h4C, 32'h3D, "R4 bank2 ctrl");
    chk("R4 bank2 ctrl slice", 64'(cfg_ctrl[16 +: 8]), 64'h3D);

    // R6 events set sticky flags
    evt_bank = 3'd3; evt_size = 1'b1; cyc(); evt_size = 1'b0;
    rd(8'h6C, 32'h1, "R6 bank3 size flag");
    evt_bank = 3'd6; evt_wprot = 1'b1; evt_tout = 1'b1; cyc();
    evt_wprot = 1'b0; evt_tout = 1'b0;
    repeat (2) cyc();
    rd(8'hC0, 32'h6, "R6 bank6 flags sticky");
    // R7 write-1 clears, write-0 no effect
    wr(8'hC0, 32'h0);
    rd(8'hC0, 32'h6, "R7 write zero");
    wr(8'hC0, 32'h2);
    rd(8'hC0, 32'h4, "R7 write one clears");
    // R8 set wins over clear
    evt_bank = 3'd6; evt_tout = 1'b1;
    wr(8'hC0, 32'h4);
    evt_tout = 1'b0;
    rd(8'hC0, 32'h4, "R8 set wins");
    wr(8'h6C, 32'h7);
    rd(8'h6C, 32'h0, "R7 bank3 cleared");

    // R10 unmapped and misaligned
    wr(12'hE4, 32'hFF); wr(12'h101, 32'hFF); wr(12'h16, 32'hFFFF_FFFF);
    rd(12'hE4, 32'h0, "R10 above map");
    rd(12'h16, 32'h0, "R10 misaligned");
    rd(12'h14, 32'h80, "R10 bank0 ctrl untouched");

    // R9 wait status tracking
    wait_act = 1'b1;
    rd(12'hE0, 32'h0, "R9 not armed");
    early_term = 1'b1; cyc(); early_term = 1'b0;
    rd(12'hE0, 32'h1, "R9 armed live high");
    rd(12'hE0, 32'h1, "R9 still armed");
    wait_act = 1'b0;
    rd(12'hE0, 32'h0, "R9 low reads zero");
    wait_act = 1'b1;
    rd(12'hE0, 32'h0, "R9 disarmed after low");
    wr(12'hE0, 32'h1);
    rd(12'hE0, 32'h0, "R9 write ignored");

    repeat (4) cyc();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule